// File: doc/BRIEF.md
# ATM Transmit Cell Processor

This block feeds a downstream framer with 53-octet ATM cells, one octet per clock. When the framer pulses a cell request, the block checks the transmit cell FIFO. If the FIFO holds a cell, the block pulls that cell through a byte-wide read port. If the FIFO is empty at that moment, the block makes an idle cell instead. The FIFO read port has first-word-fall-through behaviour: the octet at the head is visible while the empty flag is low, and a read strobe removes it. The FIFO only shows non-empty when a whole cell is stored.

On the way through, the block replaces the fifth header octet with a freshly computed header error control (HEC) value. Any value the FIFO supplied in that position is thrown away. The 48 payload octets pass through a self-synchronizing scrambler. The four leading header octets leave unchanged. A counter records how many cells were taken from the FIFO. Idle cells are not counted. A clear strobe resets the counter.

Output octets are registered. Each octet appears one cycle after the cycle in which the downstream ready input was high and the octet was consumed. The first octet of every cell carries a start-of-cell marker.

Top module: `atm_tx_cell_proc`

## Requirements
- R1: While reset is held, out_valid, out_soc and fifo_rd_en are low and cell_count is zero.
- R2: A cell_req seen while no cell is in progress and fifo_empty is low starts a FIFO cell. Exactly 53 octets are popped, one pop per consumed octet, and out_soc is high on the first emitted octet only.
- R3: A cell_req seen while fifo_empty is high starts an idle cell. Its header octets 1 to 4 are 0x00 0x00 0x00 0x01, its payload octets are 0x6A before scrambling, and no FIFO read is made.
- R4: Octet 5 of every emitted cell is the CRC-8 (generator x^8+x^2+x+1, zero initial value, MSB first) of octets 1 to 4, XORed with 0x55. The fifth octet read from the FIFO is discarded.
- R5: Payload octets (6 to 53) are scrambled MSB first. Each output bit is the input bit XORed with the output bit 43 positions earlier. The scrambler history is zero after reset and continues across cells, idle cells included.
- R6: Header octets 1 to 4 are emitted unscrambled, and the scrambler history does not advance during any header octet.
- R7: One octet is consumed in each cycle in which a cell is in progress and out_ready is high, and none otherwise. out_valid rises in the cycle after consumption. With out_ready held high, a cell's 53 octets appear on 53 consecutive cycles, the last one 53 cycles after the request cycle.
- R8: A cell_req that arrives while a cell is in progress is ignored: it causes no FIFO read and no extra cell.
- R9: cell_count rises by one when the last octet of a FIFO cell is consumed. Idle cells leave it unchanged.
- R10: cell_count is CNT_W bits wide and wraps to zero after its maximum value.
- R11: cnt_clr sets cell_count to zero on the next cycle, and it wins over an increment that falls in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_req | input | 1 | Framer strobe asking for the next cell |
| fifo_empty | input | 1 | High when the transmit FIFO holds no complete cell |
| fifo_rd_data | input | 8 | Head octet of the transmit FIFO |
| fifo_rd_en | output | 1 | Pops the head octet of the FIFO |
| out_ready | input | 1 | Downstream can take an octet this cycle |
| out_data | output | 8 | Processed cell octet |
| out_valid | output | 1 | out_data holds an octet |
| out_soc | output | 1 | Marks the first octet of a cell |
| cnt_clr | input | 1 | Clears the transferred-cell counter |
| cell_count | output | CNT_W | Number of cells taken from the FIFO |

## Verification
Two events are hard to reach from the ports. One is a clear strobe landing in exactly the cycle that the last octet of a FIFO cell is consumed. The bench counts cycles from the request with out_ready held high, so it can place cnt_clr on cycle 53. The other is counter wrap. A second instance with a 3-bit counter shares every input with the main instance, so a handful of FIFO cells carries it past its maximum. A request raised in the middle of a cell, while a second cell waits in the FIFO, shows that busy requests neither pop the FIFO nor start a new cell.

// File: rtl/atm_tx_pkg.sv
package atm_tx_pkg;

  localparam int CELL_OCTETS = 53;
  localparam int HDR_OCTETS  = 5;
  localparam int HEC_POS     = 4;
  localparam int IDX_W       = $clog2(CELL_OCTETS);
  localparam int SCR_LEN     = 43;
  localparam logic [7:0] HEC_POLY   = 8'h07;
  localparam logic [7:0] HEC_COSET  = 8'h55;
  localparam logic [7:0] IDLE_FILL  = 8'h6A;

  typedef logic [IDX_W-1:0] oct_idx_t;

  typedef enum logic {SRC_IDLE = 1'b0, SRC_FIFO = 1'b1} cell_src_e;

  typedef struct packed {
    logic [SCR_LEN-1:0] st;
    logic [7:0]         q;
  } scr_res_t;

  // One octet of CRC-8 update, most significant bit first.
  function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] d);
    logic [7:0] c;
    c = crc ^ d;
    for (int b = 0; b < 8; b++) begin
      c = c[7] ? ((c << 1) ^ HEC_POLY) : (c << 1);
    end
    return c;
  endfunction

  // Raw octet of the idle cell at a given position.
  function automatic logic [7:0] idle_octet(input oct_idx_t idx);
    if (idx < oct_idx_t'(3))      return 8'h00;
    else if (idx == oct_idx_t'(3)) return 8'h01;
    else                           return IDLE_FILL;
  endfunction

  // Self-synchronizing x^43+1 scrambling of one octet, MSB first.
  function automatic scr_res_t scr_step(input logic [SCR_LEN-1:0] st, input logic [7:0] d);
    scr_res_t r;
    r.st = st;
    r.q  = '0;
    for (int b = 7; b >= 0; b--) begin
      r.q[b] = d[b] ^ r.st[SCR_LEN-1];
      r.st   = {r.st[SCR_LEN-2:0], r.q[b]};
    end
    return r;
  endfunction

endpackage

// File: rtl/atm_hec_gen.sv
module atm_hec_gen
  import atm_tx_pkg::*;
#(
  parameter logic [7:0] COSET = HEC_COSET
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       first,
  input  logic [7:0] din,
  output logic [7:0] hec
);
  logic [7:0] crc_q;
  logic [7:0] seed;

  assign seed = first ? 8'h00 : crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  crc_q <= 8'h00;
    else if (en) crc_q <= crc8_step(seed, din);
  end

  assign hec = crc_q ^ COSET;

  // R4: the running remainder only moves on header octets
  p_crc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(crc_q));
endmodule

// File: rtl/atm_payload_scrambler.sv
module atm_payload_scrambler
  import atm_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  input  logic [7:0] din,
  output logic [7:0] dout
);
  logic [SCR_LEN-1:0] hist_q;
  scr_res_t           step;

  assign step = scr_step(hist_q, din);
  assign dout = step.q;

  always_ff @(posedge clk) begin
    if (!rst_n)   hist_q <= '0;
    else if (adv) hist_q <= step.st;
  end

  // R6: history frozen outside payload octets
  p_hist_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(hist_q));
  // R5: the newest history bit is the last scrambled output bit
  p_hist_feed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> hist_q[0] == $past(dout[0]));
endmodule

// File: rtl/atm_cell_counter.sv
module atm_cell_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) count <= '0;
    else if (inc)      count <= count + 1'b1;
  end

  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> count == '0);
  p_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && count != CNT_MAX) |=> count == $past(count) + 1'b1);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !clr) |=> $stable(count));
  p_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && count == CNT_MAX) |=> count == '0);
endmodule

// File: rtl/atm_tx_cell_proc.sv
module atm_tx_cell_proc
  import atm_tx_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cell_req,
  input  logic             fifo_empty,
  input  logic [7:0]       fifo_rd_data,
  output logic             fifo_rd_en,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_valid,
  output logic             out_soc,
  input  logic             cnt_clr,
  output logic [CNT_W-1:0] cell_count
);
  localparam oct_idx_t LAST_IDX = oct_idx_t'(CELL_OCTETS - 1);
  localparam oct_idx_t HEC_IDX  = oct_idx_t'(HEC_POS);
  localparam oct_idx_t PAY_IDX  = oct_idx_t'(HDR_OCTETS);

  logic      active_q;
  cell_src_e src_q;
  oct_idx_t  idx_q;

  // named events
  logic cell_start, take_octet, cell_done, at_hec, in_payload, from_fifo;
  logic [7:0] raw_octet, hec_octet, scr_octet, next_octet;

  assign from_fifo  = (src_q == SRC_FIFO);
  assign cell_start = cell_req && !active_q;
  assign take_octet = active_q && out_ready;
  assign cell_done  = take_octet && (idx_q == LAST_IDX);
  assign at_hec     = (idx_q == HEC_IDX);
  assign in_payload = (idx_q >= PAY_IDX);

  assign raw_octet  = from_fifo ? fifo_rd_data : idle_octet(idx_q);
  assign fifo_rd_en = take_octet && from_fifo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      src_q    <= SRC_IDLE;
      idx_q    <= '0;
    end else if (cell_start) begin
      active_q <= 1'b1;
      src_q    <= fifo_empty ? SRC_IDLE : SRC_FIFO;
      idx_q    <= '0;
    end else if (take_octet) begin
      if (cell_done) begin
        active_q <= 1'b0;
        idx_q    <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  atm_hec_gen u_hec (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (take_octet && (idx_q < HEC_IDX)),
    .first (idx_q == '0),
    .din   (raw_octet),
    .hec   (hec_octet)
  );

  atm_payload_scrambler u_scr (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (take_octet && in_payload),
    .din   (raw_octet),
    .dout  (scr_octet)
  );

  atm_cell_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .inc   (cell_done && from_fifo),
    .count (cell_count)
  );

  always_comb begin
    if (at_hec)          next_octet = hec_octet;
    else if (in_payload) next_octet = scr_octet;
    else                 next_octet = raw_octet;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_soc   <= 1'b0;
      out_data  <= 8'h00;
    end else begin
      out_valid <= take_octet;
      out_soc   <= take_octet && (idx_q == '0);
      if (take_octet) out_data <= next_octet;
    end
  end

  p_no_pop_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd_en |-> !fifo_empty);
  p_soc_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_soc |-> out_valid);
  p_valid_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(out_ready));
  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !cell_done) |=> (active_q && $stable(src_q)));
  p_idle_no_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_start && fifo_empty) |=> !fifo_rd_en);
endmodule

// File: tb/atm_tx_cell_proc_tb.sv
`timescale 1ns/1ps
module atm_tx_cell_proc_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cell_req = 1'b0, out_ready = 1'b0, cnt_clr = 1'b0;
  logic fifo_empty, fifo_rd_en;
  logic [7:0] fifo_rd_data, out_data;
  logic out_valid, out_soc;
  logic [31:0] cell_count;
  logic [2:0] small_count;
  logic w_rd_en, w_valid, w_soc;
  logic [7:0] w_data;

  always #10 clk = ~clk;

  // bench FIFO, holds whole cells only
  logic [7:0] fmem [0:2047];
  int rd_ptr = 0, wr_ptr = 0;
  assign fifo_empty   = (rd_ptr == wr_ptr);
  assign fifo_rd_data = fmem[rd_ptr[10:0]];
  always @(posedge clk) if (!rst_n) rd_ptr <= 0; else if (fifo_rd_en) rd_ptr <= rd_ptr + 1;

  atm_tx_cell_proc u_dut (
    .clk(clk), .rst_n(rst_n), .cell_req(cell_req), .fifo_empty(fifo_empty),
    .fifo_rd_data(fifo_rd_data), .fifo_rd_en(fifo_rd_en), .out_ready(out_ready),
    .out_data(out_data), .out_valid(out_valid), .out_soc(out_soc),
    .cnt_clr(cnt_clr), .cell_count(cell_count));

  atm_tx_cell_proc #(.CNT_W(3)) u_dut_w (
    .clk(clk), .rst_n(rst_n), .cell_req(cell_req), .fifo_empty(fifo_empty),
    .fifo_rd_data(fifo_rd_data), .fifo_rd_en(w_rd_en), .out_ready(out_ready),
    .out_data(w_data), .out_valid(w_valid), .out_soc(w_soc),
    .cnt_clr(cnt_clr), .cell_count(small_count));

  int n_chk = 0, n_bad = 0, exp_cnt = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // reference HEC by long division of header*x^8
  function automatic logic [7:0] ref_hec(input logic [31:0] h);
    logic [39:0] r;
    r = {h, 8'h00};
    for (int i = 39; i >= 8; i--) if (r[i]) r[i -: 9] = r[i -: 9] ^ 9'h107;
    return r[7:0] ^ 8'h55;
  endfunction

  // expected raw stream and collector
  logic [7:0] exp_raw [0:4095];
  int exp_wr = 0, exp_rd = 0, cidx = 0;
  logic [31:0] hdr_seen;
  bit hist [0:42];
  int hptr = 0;
  initial for (int i = 0; i < 43; i++) hist[i] = 1'b0;

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_rd >= exp_wr) begin
        chk(1'b0, "R7 unexpected octet", {24'h0, out_data}, 32'h0);
      end else begin
        logic [7:0] raw, e;
        raw = exp_raw[exp_rd[11:0]];
        if (cidx < 4) begin
          e = raw;
          hdr_seen = {hdr_seen[23:0], raw};
          chk(out_data == e, "R6 header octet", {24'h0, out_data}, {24'h0, e});
        end else if (cidx == 4) begin
          e = ref_hec(hdr_seen);
          chk(out_data == e, "R4 hec octet", {24'h0, out_data}, {24'h0, e});
        end else begin
          for (int b = 7; b >= 0; b--) begin
            e[b] = raw[b] ^ hist[hptr];
            hist[hptr] = e[b];
            hptr = (hptr + 1) % 43;
          end
          chk(out_data == e, "R5 payload octet", {24'h0, out_data}, {24'h0, e});
        end
        chk(out_soc == (cidx == 0), "R2 start marker", {31'h0, out_soc}, {31'h0, cidx == 0});
        exp_rd++;
        cidx = (cidx + 1) % 53;
      end
    end
  end

  task automatic push_fifo(input logic [31:0] h, input logic [7:0] p0);
    for (int i = 0; i < 4; i++) fmem[(wr_ptr + i) % 2048] = h[31 - 8*i -: 8];
    fmem[(wr_ptr + 4) % 2048] = 8'hFF;  // stale HEC, must be replaced (R4)
    for (int i = 5; i < 53; i++) fmem[(wr_ptr + i) % 2048] = p0 + 8'(i);
    wr_ptr = wr_ptr + 53;
  endtask

  task automatic push_exp(input bit wc, input logic [31:0] h, input logic [7:0] p0);
    for (int i = 0; i < 53; i++) begin
      logic [7:0] v;
      if (!wc) v = (i < 3) ? 8'h00 : (i == 3) ? 8'h01 : 8'h6A;
      else if (i < 4) v = h[31 - 8*i -: 8];
      else if (i == 4) v = 8'h00;
      else v = p0 + 8'(i);
      exp_raw[(exp_wr + i) % 4096] = v;
    end
    exp_wr = exp_wr + 53;
  endtask

  task automatic run_cell(input bit wc, input logic [31:0] h, input logic [7:0] p0,
                          input bit stall, input bit preloaded);
    int rd0, cyc;
    if (wc && !preloaded) push_fifo(h, p0);
    push_exp(wc, h, p0);
    @(negedge clk); rd0 = rd_ptr; cell_req = 1'b1; out_ready = 1'b1;
    @(negedge clk); cell_req = 1'b0;
    cyc = 0;
    while (exp_rd != exp_wr && cyc < 400) begin
      if (stall) out_ready = ~out_ready;
      @(negedge clk); #1; cyc++;
    end
    out_ready = 1'b1;
    if (!stall) chk(cyc == 53, "R7 53 consecutive octets", cyc, 53);
    if (wc) begin
      chk(rd_ptr - rd0 == 53, "R2 pops per cell", rd_ptr - rd0, 53);
      exp_cnt++;
    end else begin
      chk(rd_ptr == rd0, "R3 idle cell reads nothing", rd_ptr - rd0, 0);
    end
    chk(cell_count == exp_cnt, "R9 transferred count", cell_count, exp_cnt);
    chk(small_count == 3'(exp_cnt), "R10 narrow counter wrap", {29'h0, small_count}, exp_cnt % 8);
  endtask

  // hdr[41:10] pay0[9:2] with_cell[1] stall[0]
  localparam logic [41:0] VECS [0:5] = '{
    {32'h0012_3450, 8'h00, 1'b1, 1'b0},
    {32'h0000_0000, 8'h00, 1'b0, 1'b0},
    {32'hFFFF_FFFE, 8'hA5, 1'b1, 1'b1},
    {32'h0ABC_DEF2, 8'h3C, 1'b1, 1'b0},
    {32'h0000_0000, 8'h00, 1'b0, 1'b1},
    {32'h7F00_1230, 8'hF0, 1'b1, 1'b1}
  };

  initial begin
    repeat (3) @(negedge clk);
    chk(!out_valid && !out_soc && !fifo_rd_en, "R1 reset outputs", {out_valid, out_soc, fifo_rd_en}, 0);
    chk(cell_count == 0, "R1 reset count", cell_count, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 6; v++)
      run_cell(VECS[v][1], VECS[v][41:10], VECS[v][9:2], VECS[v][0], 1'b0);

    // R3 known idle HEC value
    chk(ref_hec(32'h1) == 8'h52, "R3 idle header HEC", {24'h0, ref_hec(32'h1)}, 32'h52);

    // R8: request in mid-cell with a second cell waiting
    begin
      int rd0;
      push_fifo(32'h0101_0100, 8'h11);
      push_fifo(32'h0202_0200, 8'h22);
      push_exp(1'b1, 32'h0101_0100, 8'h11);
      @(negedge clk); rd0 = rd_ptr; cell_req = 1'b1; out_ready = 1'b1;
      @(negedge clk); cell_req = 1'b0;
      repeat (20) @(negedge clk);
      cell_req = 1'b1;
      @(negedge clk); cell_req = 1'b0;
      while (exp_rd != exp_wr) @(negedge clk);
      repeat (8) @(negedge clk);
      #1;
      chk(rd_ptr - rd0 == 53, "R8 busy request ignored", rd_ptr - rd0, 53);
      chk(!out_valid, "R8 no extra cell", {31'h0, out_valid}, 0);
      exp_cnt++;
      run_cell(1'b1, 32'h0202_0200, 8'h22, 1'b0, 1'b1);
    end

    for (int k = 0; k < 3; k++) run_cell(1'b1, 32'h00AB_0000 + k, 8'(k * 7), 1'b0, 1'b0);
    chk(small_count == 3'd1, "R10 wrapped past max", {29'h0, small_count}, 1);

    // R11 plain clear
    @(negedge clk); cnt_clr = 1'b1;
    @(negedge clk); cnt_clr = 1'b0; #1;
    chk(cell_count == 0, "R11 clear", cell_count, 0);
    exp_cnt = 0;

    // R11 clear in the same cycle as an increment
    push_fifo(32'h0033_0000, 8'h5A);
    push_exp(1'b1, 32'h0033_0000, 8'h5A);
    @(negedge clk); cell_req = 1'b1; out_ready = 1'b1;
    @(negedge clk); cell_req = 1'b0;
    repeat (52) @(negedge clk);
    cnt_clr = 1'b1;
    @(negedge clk); cnt_clr = 1'b0; #1;
    chk(exp_rd == exp_wr, "R7 last octet on cycle 53", exp_wr - exp_rd, 0);
    chk(cell_count == 0, "R11 clear beats increment", cell_count, 0);

    run_cell(1'b1, 32'h0044_0000, 8'h01, 1'b0, 1'b0);
    run_cell(1'b0, 32'h0, 8'h00, 1'b0, 1'b0);

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule